// File: doc/BRIEF.md
# Synchronous Serial Master on a USART Core

This block is the master side of a four-wire style synchronous serial link, built around a USART datapath that runs in a clocked master mode. It generates the serial clock, shifts 8-bit characters out on its transmit data line and captures 8-bit characters from its receive data line at the same time. Clock polarity, clock phase and bit order are plain configuration inputs; the serial clock rate comes from a 12-bit divisor.

The host loads bytes through a valid/ready port backed by a single holding register, so the next byte can be queued while the current one shifts and frames then follow one another with no idle gap. Every completed frame delivers its received byte with a one-cycle valid strobe. When nothing is pending the data line rests high and the serial clock rests at the polarity level. Slave-select generation is left to surrounding logic.

Top module: `usart_spi_master`

## Requirements
- R1: During and right after reset, `sclk` equals `clkPolarity`, `mosi` is 1, `busy` is 0, `rxValid` is 0 and `txReady` is 1.
- R2: Mode {clkPolarity, clkPhase}: data is sampled on the rising `sclk` edge when the two bits are equal (modes 0 and 3) and on the falling edge otherwise (modes 1 and 2); `mosi` changes only away from sampling edges, so it is stable at every sampling edge.
- R3: Each half period of `sclk` lasts exactly `baudDiv`+1 system clocks while a transfer runs.
- R4: A frame is exactly 8 data bits with no start, stop or parity bit: 8 sampling edges per frame.
- R5: With `lsbFirst`=1 bit 0 is sent and received first; with `lsbFirst`=0 bit 7 goes first; the one setting governs both directions.
- R6: After each frame the received byte appears on `rxByte` together with `rxValid` high for exactly one system clock.
- R7: A byte is accepted on a clock edge where `txValid` and `txReady` are both high; `txReady` then stays low until the holding register is moved into the shifter.
- R8: When a byte is waiting as a frame ends, the next frame starts with no gap: the `sclk` edge spacing stays `baudDiv`+1 clocks across the frame boundary.
- R9: With no transfer and no waiting byte, `busy` is 0, `mosi` is 1 and `sclk` follows `clkPolarity`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clkPolarity | input | 1 | Idle level of the serial clock |
| clkPhase | input | 1 | 0: sample on leading edge; 1: sample on trailing edge |
| lsbFirst | input | 1 | Bit order for both directions, 1 = LSB first |
| baudDiv | input | 12 | Half period of sclk minus one, in system clocks |
| txByte | input | 8 | Byte to transmit |
| txValid | input | 1 | txByte is valid |
| txReady | output | 1 | Holding register is free |
| rxByte | output | 8 | Last received byte |
| rxValid | output | 1 | One-cycle strobe, rxByte updated |
| busy | output | 1 | A frame is shifting or a byte is waiting |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Transmit data line |
| miso | input | 1 | Receive data line |

## Verification
The assertions assume that polarity, phase, bit order and divisor are only changed while `busy` is low, and that `miso` settles well before each sampling edge. The stimulus respects this by writing the configuration only between transfers and by having the bench slave model change `miso` right after a sampling edge, a full half period ahead of the next one. Configuration changes in mid-frame are not exercised.

// File: rtl/spim_pkg.sv
package spim_pkg;
  // Strobes issued by the control to the datapath, one cycle wide each.
  typedef struct packed {
    logic load;    // move holding register into the shifter, start a frame
    logic sample;  // capture the receive line
    logic shift;   // advance the transmit shifter to the next bit
    logic finish;  // last bit done, publish the received byte
  } spimStrobe_t;
endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             holdFull,
  output spimStrobe_t      stb,
  output logic             active,
  output logic             phaseB
);
  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic halfEnd;
  logic lastBit;
  logic frameEnd;

  always_comb begin
    halfEnd    = active && (divCnt >= divisor);
    lastBit    = (bitCnt == LAST_BIT);
    frameEnd   = halfEnd && phaseB && lastBit;
    stb.load   = holdFull && (!active || frameEnd);
    stb.sample = halfEnd && !phaseB;
    stb.shift  = halfEnd && phaseB && !lastBit;
    stb.finish = frameEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      phaseB <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (stb.load) begin
      active <= 1'b1;
      phaseB <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (frameEnd) begin
      active <= 1'b0;
      phaseB <= 1'b0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (halfEnd) begin
      divCnt <= '0;
      phaseB <= !phaseB;
      if (phaseB) bitCnt <= bitCnt + 1'b1;
    end else if (active) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // R3: inside a half period the counter advances by one each clock
  a_r3_half_count: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !halfEnd && !stb.load) |=> (divCnt == DIV_W'($past(divCnt) + 1'b1)));

  // R4: a bit ends after its second half and the bit counter steps once
  a_r4_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    stb.shift |=> (bitCnt == BIT_W'($past(bitCnt) + 1'b1)) && !phaseB);

  // R8: a load always opens a fresh frame in its first half
  a_r8_reload_fresh: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> active && !phaseB && (bitCnt == '0) && (divCnt == '0));

  // R9: a frame ending with nothing waiting returns to idle
  a_r9_stop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (frameEnd && !holdFull) |=> !active);
endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkPolarity,
  input  logic              clkPhase,
  input  logic              lsbFirst,
  input  spimStrobe_t       stb,
  input  logic              active,
  input  logic              phaseB,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txValid,
  output logic              txReady,
  output logic              holdFull,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
    end else if (txValid && !holdFull) begin
      holdReg  <= txByte;
      holdFull <= 1'b1;
    end else if (stb.load) begin
      holdFull <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txShift <= '1;
    end else if (stb.load) begin
      txShift <= holdReg;
    end else if (stb.shift) begin
      txShift <= lsbFirst ? (txShift >> 1) : (txShift << 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      if (stb.sample)
        rxShift <= lsbFirst ? {miso, rxShift[DATA_W-1:1]} : {rxShift[DATA_W-2:0], miso};
      rxValid <= stb.finish;
      if (stb.finish) rxByte <= rxShift;
    end
  end

  always_comb begin
    txReady = !holdFull;
    mosi    = active ? (lsbFirst ? txShift[0] : txShift[DATA_W-1]) : 1'b1;
    sclk    = active ? (clkPolarity ^ (phaseB ? !clkPhase : clkPhase)) : clkPolarity;
  end

  // R7: an accepted byte occupies the holding register on the next cycle
  a_r7_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (txValid && txReady) |=> !txReady);

  // R6: the receive strobe never lasts two cycles
  a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    rxValid |=> !rxValid);

  // R2: the transmit line holds still on the clock edge that samples
  a_r2_no_change_at_sample: assert property (@(posedge clk) disable iff (!rst_n)
    stb.sample |=> $stable(mosi));
endmodule

// File: rtl/usart_spi_master.sv
module usart_spi_master
  import spim_pkg::*;
#(
  parameter int DIV_W  = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkPolarity,
  input  logic              clkPhase,
  input  logic              lsbFirst,
  input  logic [DIV_W-1:0]  baudDiv,
  input  logic [DATA_W-1:0] txByte,
  input  logic              txValid,
  output logic              txReady,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso
);
  spimStrobe_t stb;
  logic active;
  logic phaseB;
  logic holdFull;

  spim_ctrl #(.DIV_W(DIV_W), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .divisor(baudDiv), .holdFull(holdFull),
    .stb(stb), .active(active), .phaseB(phaseB)
  );

  spim_dp #(.DATA_W(DATA_W)) uDp (
    .clk(clk), .rst_n(rst_n), .clkPolarity(clkPolarity), .clkPhase(clkPhase),
    .lsbFirst(lsbFirst), .stb(stb), .active(active), .phaseB(phaseB),
    .txByte(txByte), .txValid(txValid), .txReady(txReady), .holdFull(holdFull),
    .rxByte(rxByte), .rxValid(rxValid), .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  assign busy = active || holdFull;

  // R1: reset releases into an idle, empty state
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !busy && !rxValid);
endmodule

// File: tb/usart_spi_master_test.sv
`timescale 1ns/1ps
module usart_spi_master_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clkPolarity = 1'b0;
  logic clkPhase = 1'b0;
  logic lsbFirst = 1'b0;
  logic [11:0] baudDiv = '0;
  logic [7:0] txByte = '0;
  logic txValid = 1'b0;
  logic miso;
  logic txReady, rxValid, busy, sclk, mosi;
  logic [7:0] rxByte;

  int vectors = 0;
  int fails = 0;
  int monVec = 0;
  int monFail = 0;

  logic [7:0] slaveBytes [0:3];
  logic [7:0] capArr [0:3];
  logic [7:0] rxArr [0:1023];
  int rxCount = 0;

  always #2.5 clk = ~clk;

  usart_spi_master uut (
    .clk(clk), .rst_n(rst_n), .clkPolarity(clkPolarity), .clkPhase(clkPhase),
    .lsbFirst(lsbFirst), .baudDiv(baudDiv), .txByte(txByte), .txValid(txValid),
    .txReady(txReady), .rxByte(rxByte), .rxValid(rxValid), .busy(busy),
    .sclk(sclk), .mosi(mosi), .miso(miso)
  );

  function automatic logic bitAt(logic [7:0] b, int idx, logic lsb);
    return lsb ? b[idx] : b[7-idx];
  endfunction

  // Slave model and output monitor, sampled on the falling clock edge.
  int bitIdx = 0, frameNo = 0, edgeIdx = 0, sinceEdge = 0;
  logic prevSclk = 1'b0, prevMosi = 1'b1, prevRxValid = 1'b0;
  always @(negedge clk) begin
    if (!rst_n || !busy) begin
      bitIdx = 0; frameNo = 0; edgeIdx = 0; sinceEdge = 0;
      miso = bitAt(slaveBytes[0], 0, lsbFirst);
    end else begin
      sinceEdge++;
      if (sclk != prevSclk) begin
        if (edgeIdx > 0) begin
          monVec++;  // R3 and R8: edge spacing, also across frame boundaries
          if (sinceEdge != int'(baudDiv) + 1) begin
            monFail++;
            $display("FAIL R3/R8 edge spacing actual=%0d expected=%0d", sinceEdge, int'(baudDiv) + 1);
          end
        end
        edgeIdx++;
        sinceEdge = 0;
        if (sclk == (clkPolarity == clkPhase)) begin
          monVec++;  // R2: data stable on the sampling edge
          if (mosi != prevMosi) begin
            monFail++;
            $display("FAIL R2 mosi moved at sample edge actual=%0b expected=%0b", mosi, prevMosi);
          end
          capArr[frameNo][lsbFirst ? bitIdx : 7 - bitIdx] = mosi;
          bitIdx++;
          if (bitIdx == 8) begin
            bitIdx = 0;
            if (frameNo < 3) frameNo++;
          end
          miso = bitAt(slaveBytes[frameNo], bitIdx, lsbFirst);
        end
      end
    end
    if (rxValid) begin
      rxArr[rxCount] = rxByte;
      rxCount++;
      if (prevRxValid) begin
        monVec++;
        monFail++;
        $display("FAIL R6 rxValid wider than one cycle actual=2 expected=1");
      end
    end
    prevSclk = sclk;
    prevMosi = mosi;
    prevRxValid = rxValid;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runFrames(input logic cp, input logic ch, input logic lsb,
                           input logic [11:0] div, input int n, input logic [7:0] seed);
    logic [7:0] sent [0:3];
    int base;
    @(negedge clk);
    clkPolarity = cp; clkPhase = ch; lsbFirst = lsb; baudDiv = div;
    for (int k = 0; k < 4; k++) begin
      sent[k] = seed + 8'(k * 71);
      slaveBytes[k] = {sent[k][3:0], sent[k][7:4]} ^ 8'h3C;
    end
    @(negedge clk);
    base = rxCount;
    for (int k = 0; k < n; k++) begin
      txByte = sent[k];
      txValid = 1'b1;
      while (!txReady) @(negedge clk);
      @(negedge clk);  // accepted on the rising edge just passed
      if (k == 0) check(!txReady, "R7 txReady after accept", txReady, 0);
    end
    txValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(rxCount - base == n, "R6 strobe count", rxCount - base, n);
    for (int k = 0; k < n; k++) begin
      check(capArr[k] == sent[k], "R5/R4 bits seen by slave", capArr[k], sent[k]);
      check(rxArr[base + k] == slaveBytes[k], "R5/R6 received byte", rxArr[base + k], slaveBytes[k]);
    end
    check(sclk == cp, "R9 idle sclk", sclk, cp);
    check(mosi == 1'b1, "R9 idle mosi", mosi, 1);
    check(!busy && txReady, "R9 idle busy/ready", {busy, txReady}, 1);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) slaveBytes[k] = 8'h00;
    repeat (3) @(negedge clk);
    check(sclk == 1'b0 && mosi == 1'b1, "R1 lines in reset", {sclk, mosi}, 1);
    check(!busy && !rxValid && txReady, "R1 flags in reset", {busy, rxValid, txReady}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !rxValid && txReady && mosi, "R1 after reset", {busy, rxValid, txReady, mosi}, 7);
    clkPolarity = 1'b1;
    @(negedge clk);
    check(sclk == 1'b1, "R9 idle sclk follows polarity", sclk, 1);
    for (int m = 0; m < 4; m++)
      for (int l = 0; l < 2; l++)
        for (int d = 0; d < 3; d++) begin
          runFrames(m[1], m[0], l[0], (d == 2) ? 12'd3 : 12'(d), 1, 8'(8'hA5 ^ (m * 37 + l * 11 + d * 5)));
          if (d == 1)  // R8: three frames queued back to back
            runFrames(m[1], m[0], l[0], 12'd2, 3, 8'(8'h1E + m * 13 + l * 7));
        end
    runFrames(1'b0, 1'b0, 1'b0, 12'd0, 1, 8'h00);
    runFrames(1'b1, 1'b1, 1'b1, 12'd0, 1, 8'hFF);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors + monVec, fails + monFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors + monVec + 1, fails + monFail + 1);
    $finish;
  end
endmodule